// File: doc/BRIEF.md
# Shared-Adder Arithmetic Logic Unit

This block is a purely combinational ALU with a parameterised word width. It takes two operands, an incoming carry/borrow flag and a 4-bit operation code. It returns a result word together with carry/borrow, zero and negative flags. The logic settles within the same cycle, and the surrounding datapath registers whatever it needs.

The block has two parts. The arithmetic part covers add, add-with-carry, subtract, subtract-with-borrow and negate. It does all five through one adder, and small multiplexers set that adder's two operands and its carry-in. The logic part produces bitwise results. Bit 3 of the operation code selects which part drives the output. Codes that are not assigned produce zero.

Top module: `shared_adder_alu`

## Requirements
- R1: Code 0 (add) gives result = (A + B) mod 2^W. carry_out is bit W of the full sum.
- R2: Code 1 (add with carry) gives result = (A + B + carry_in) mod 2^W. carry_out is bit W of that sum.
- R3: Code 2 (subtract) gives result = (A − B) mod 2^W. carry_out is 1 exactly when A < B, which means a borrow occurred.
- R4: Code 3 (subtract with borrow) gives result = (A − B − carry_in) mod 2^W. carry_out is 1 exactly when A < B + carry_in.
- R5: Code 4 (negate) gives result = (0 − A) mod 2^W. carry_out is 1 exactly when A is nonzero.
- R6: Codes 8, 9, 10 and 11 give A AND B, A OR B, A XOR B and NOT A respectively. For these codes carry_out is 0 and carry_in has no effect.
- R7: Codes 5, 6, 7 and 12 to 15 give a result of 0 and a carry_out of 0.
- R8: zero is 1 exactly when every bit of result is 0.
- R9: negative equals the most significant bit of result.
- R10: R1 to R9 hold for W = 16 (the default) and for W = 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Incoming carry (add) or borrow (subtract) flag |
| op_sel | input | 4 | Operation code |
| result | output | WIDTH | Result word |
| carry_out | output | 1 | Carry after add, borrow after subtract or negate |
| zero | output | 1 | Result is all zeros |
| negative | output | 1 | Result most significant bit |

## Verification
The bench targets the borrow polarity. A design that passes the raw adder carry-out through on subtract would report a borrow exactly when none occurred, for example on 5 − 3.

Subtract-with-borrow is run with carry_in at both values and with A equal to B. A carry-in that is not inverted shows up as an off-by-one result.

Negation of zero and of the most negative value catches a wrong carry-in or a wrong flag. The bench also drives unused codes and logic codes with carry_in set, to expose a result or carry that leaks from the adder. Every pattern runs against both a 16-bit and a 4-bit instance, so any width handling that is hard-coded fails at one of the two sizes.

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic [2:0]       fn,
  output logic [WIDTH-1:0] sum,
  output logic             flag
);
  logic             is_neg, is_sub;
  logic [WIDTH-1:0] x, y;
  logic             ci, co;

  assign is_neg = (fn == 3'd4);
  assign is_sub = (fn == 3'd2) || (fn == 3'd3) || is_neg;

  assign x = is_neg ? '0 : a;
  assign y = is_neg ? ~a : (is_sub ? ~b : b);

  always_comb begin
    case (fn)
      3'd1:    ci = cin;
      3'd2:    ci = 1'b1;
      3'd3:    ci = ~cin;
      3'd4:    ci = 1'b1;
      default: ci = 1'b0;
    endcase
  end

  assign {co, sum} = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci};
  assign flag = is_sub ? ~co : co;
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       fn,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    case (fn)
      2'd0:    y = a & b;
      2'd1:    y = a | b;
      2'd2:    y = a ^ b;
      default: y = ~a;
    endcase
  end
endmodule

// File: rtl/shared_adder_alu.sv
module shared_adder_alu #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  input  logic [3:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             zero,
  output logic             negative
);
  logic [WIDTH-1:0] arith_y, logic_y;
  logic             arith_c, arith_ok, logic_ok;

  alu_arith #(.WIDTH(WIDTH)) arith_u (
    .a(op_a), .b(op_b), .cin(carry_in), .fn(op_sel[2:0]),
    .sum(arith_y), .flag(arith_c)
  );

  alu_logic #(.WIDTH(WIDTH)) logic_u (
    .a(op_a), .b(op_b), .fn(op_sel[1:0]), .y(logic_y)
  );

  assign arith_ok  = ~op_sel[3] & (op_sel[2:0] <= 3'd4);
  assign logic_ok  = op_sel[3] & ~op_sel[2];
  assign result    = arith_ok ? arith_y : (logic_ok ? logic_y : '0);
  assign carry_out = arith_ok & arith_c;
  assign zero      = ~|result;
  assign negative  = result[WIDTH-1];

  always_comb begin
    if (op_sel == 4'd0)
      a_r1_add: assert ({carry_out, result} == ({1'b0, op_a} + {1'b0, op_b}));
    if (op_sel == 4'd2)
      a_r3_sub_borrow: assert (carry_out == (op_a < op_b));
    if (op_sel == 4'd4)
      a_r5_neg_borrow: assert (carry_out == (op_a != '0));
    if (op_sel[3])
      a_r6_logic_no_carry: assert (!carry_out);
    if ((!op_sel[3] && op_sel[2:0] > 3'd4) || (op_sel[3] && op_sel[2]))
      a_r7_unused_zero: assert (result == '0 && !carry_out);
  end
endmodule

// File: tb/shared_adder_alu_tb_top.sv
module shared_adder_alu_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] a, b;
  logic        cin;
  logic [3:0]  sel;
  logic [15:0] r16;
  logic        c16, z16, n16;
  logic [3:0]  r4;
  logic        c4, z4, n4;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  shared_adder_alu #(.WIDTH(16)) dut_i (
    .op_a(a), .op_b(b), .carry_in(cin), .op_sel(sel),
    .result(r16), .carry_out(c16), .zero(z16), .negative(n16)
  );

  shared_adder_alu #(.WIDTH(4)) dut4_i (
    .op_a(a[3:0]), .op_b(b[3:0]), .carry_in(cin), .op_sel(sel),
    .result(r4), .carry_out(c4), .zero(z4), .negative(n4)
  );

  function automatic string req_of(input logic [3:0] s);
    case (s)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd8, 4'd9, 4'd10, 4'd11: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic longint model(input logic [3:0] s, input longint x, input longint y,
                                   input longint c, input int w);
    longint m = (longint'(1) << w) - 1;
    longint t;
    longint cy;
    case (s)
      4'd0: begin t = x + y;     cy = (t >> w) & 1; end
      4'd1: begin t = x + y + c; cy = (t >> w) & 1; end
      4'd2: begin t = x - y;     cy = (t < 0) ? 1 : 0; end
      4'd3: begin t = x - y - c; cy = (t < 0) ? 1 : 0; end
      4'd4: begin t = -x;        cy = (x != 0) ? 1 : 0; end
      4'd8:  begin t = x & y;  cy = 0; end
      4'd9:  begin t = x | y;  cy = 0; end
      4'd10: begin t = x ^ y;  cy = 0; end
      4'd11: begin t = ~x;     cy = 0; end
      default: begin t = 0; cy = 0; end
    endcase
    return (cy << w) | (t & m);
  endfunction

  task automatic check(input string tag, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h cin=%0b: got %h expected %h", tag, sel, a, b, cin, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] s, input logic [15:0] x, input logic [15:0] y, input logic c);
    longint e16, e4;
    @(posedge clk);
    sel = s; a = x; b = y; cin = c;
    @(negedge clk);
    e16 = model(s, longint'(x), longint'(y), longint'(c), 16);
    e4  = model(s, longint'(x[3:0]), longint'(y[3:0]), longint'(c), 4);
    check({req_of(s), "/R10 w16 carry:result"}, {c16, r16}, e16);
    check({req_of(s), "/R10 w4 carry:result"}, {c4, r4}, e4);
    check("R8 zero w16", z16, (e16 & 64'hFFFF) == 0);
    check("R8 zero w4", z4, (e4 & 64'hF) == 0);
    check("R9 negative w16", n16, (e16 >> 15) & 1);
    check("R9 negative w4", n4, (e4 >> 3) & 1);
  endtask

  initial begin
    logic [15:0] pa [8] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h0005, 16'h0003, 16'h7FFF, 16'h1238, 16'h0001};
    logic [15:0] pb [8] = '{16'h0000, 16'h0001, 16'h0000, 16'h0003, 16'h0005, 16'h7FFF, 16'h1238, 16'hFFFF};
    sel = 0; a = 0; b = 0; cin = 0;
    @(negedge clk);
    check("R1 reset-state add of zeros", {c16, r16, z16}, {1'b0, 16'h0, 1'b1});
    for (int s = 0; s < 16; s++)
      for (int p = 0; p < 8; p++)
        for (int c = 0; c < 2; c++)
          apply(4'(s), pa[p], pb[p], 1'(c));
    for (int i = 0; i < 3000; i++)
      apply(4'($urandom_range(0, 15)), 16'($urandom), 16'($urandom), 1'($urandom));
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule